// File: doc/BRIEF.md
# Signed Slice Recoder with Zero-Skip Compaction

This block takes a two's-complement operand and cuts it into 4-bit slices. The top slice is read as a signed value. Every lower slice starts as an unsigned value. The slices are then rewritten from the most significant one downward. A slice that comes out as minus one is replaced by zero, and its weight passes to the next lower slice as a borrow of sixteen. Long runs of sign bits in negative data therefore turn into zero slices, even when the data has few zero values.

Each output word holds three things:
- the signed slices, each 5 bits wide;
- a bitmap of the slices that are worth computing;
- a packed list of their indices, highest index first, with a count.

A downstream multiply-accumulate array can step through the list and skip every zero slice. A speculation mask arrives with each operand. It removes chosen low-order slices from the bitmap and from the list, so that their work can be skipped as well.

Transfers at both edges use valid/ready. A single register stage is controlled by a two-state machine:
- `ST_EMPTY`: no word is held. It moves to `ST_FULL` on transition LOAD, which is an accepted operand.
- `ST_FULL`: a word is held. It returns to `ST_EMPTY` on transition DRAIN, which is a consumed word with no new operand. It stays in `ST_FULL` on transition STALL, which is `out_ready` low. It also stays in `ST_FULL` on transition RELOAD, which is a consumed word replaced by a new operand in the same cycle.

Top module: `slice_recoder`

## Requirements
- R1: With OP_W = 16 there are 4 slices. Slice k is placed at bits [5k+4:5k] of `out_slices` as a 5-bit two's-complement value. Slice 3 takes the sign of the operand.
- R2: No slice above index 0 ever equals -1 (5'h1F). When a slice would be -1, it becomes 0 and the next lower slice becomes its raw value minus 16.
- R3: The sum of slice k times 16^k, over all k, equals the signed operand exactly. Lower slices stay within -16..15.
- R4: Bit k of `out_nonzero` is 1 exactly when slice k is nonzero and bit k of the speculation mask is 0.
- R5: `out_index_list` entry j, at bits [2j+1:2j], holds the j-th set bit of `out_nonzero`, counted from the most significant bit down. Unused entries read 0, and `out_count` equals the number of set bits.
- R6: `in_ready` is high when no word is held or when `out_ready` is high. An operand accepted at a clock edge appears with `out_valid` high after that edge.
- R7: While `out_valid` is high and `out_ready` is low, every output field holds its value and `in_ready` is low.
- R8: Reset clears `out_valid`.
- R9: An operand of -1 gives slices {0,0,0,-1}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken |
| in_operand | input | OP_W | Two's-complement operand |
| in_spec_mask | input | OP_W/4 | Slices removed by speculation (1 = remove) |
| out_valid | output | 1 | Output word held |
| out_ready | input | 1 | Consumer takes the word |
| out_slices | output | 5*OP_W/4 | Recoded signed slices |
| out_nonzero | output | OP_W/4 | Bitmap of surviving slices |
| out_index_list | output | OP_W/4*IDX_W | Packed indices of surviving slices |
| out_count | output | CNT_W | Number of surviving slices |

## Verification
The hardest case to reach is a borrow that ripples through several slices. In that case each rewritten -1 hands its weight further down the chain. Operands such as 0xFFF0 and 0xFF12 are chosen to drive the borrow from the sign slice down to slice 0, and down to slice 1. The RELOAD and STALL transitions are also hard to reach. The stimulus reaches them by holding `out_ready` low while a second operand waits, and then releasing it.

// File: rtl/slice_recoder_pkg.sv
package slice_recoder_pkg;
    localparam int RAW_W   = 4;
    localparam int DIGIT_W = RAW_W + 1;
    typedef logic signed [DIGIT_W-1:0] digit_t;
    typedef enum logic {ST_EMPTY, ST_FULL} stage_state_e;
endpackage

// File: rtl/slice_digit_recode.sv
module slice_digit_recode
    import slice_recoder_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N*RAW_W-1:0]   operand,
    output logic [N*DIGIT_W-1:0] digits
);
    localparam int OP_W  = N * RAW_W;
    localparam int SUM_W = OP_W + DIGIT_W;

    // Walk from the sign slice downward; a -1 above slice 0 becomes 0
    // and lends -16 into the slice beneath it.
    always_comb begin
        logic   borrow;
        digit_t cur;
        logic [RAW_W-1:0] raw;
        borrow = 1'b0;
        digits = '0;
        for (int k = N - 1; k >= 0; k--) begin
            raw = operand[k*RAW_W +: RAW_W];
            if (k == N - 1) cur = {raw[RAW_W-1], raw};
            else            cur = {borrow, raw};
            if (k > 0 && cur == digit_t'(-1)) begin
                cur    = '0;
                borrow = 1'b1;
            end else begin
                borrow = 1'b0;
            end
            digits[k*DIGIT_W +: DIGIT_W] = cur;
        end
    end

    // Guard: weighted digits rebuild the operand; no -1 above slice 0
    always_comb begin
        logic signed [SUM_W-1:0] acc;
        logic signed [SUM_W-1:0] ref_val;
        logic any_minus_one;
        digit_t dg;
        acc = '0;
        any_minus_one = 1'b0;
        for (int k = 0; k < N; k++) begin
            dg  = digits[k*DIGIT_W +: DIGIT_W];
            acc = acc + (SUM_W'(dg) <<< (RAW_W * k));
            if (k > 0 && dg == digit_t'(-1)) any_minus_one = 1'b1;
        end
        ref_val = SUM_W'($signed(operand));
        assert_exact_value_R3: assert (acc == ref_val);
        assert_no_minus_one_R2: assert (!any_minus_one);
    end
endmodule

// File: rtl/slice_skip_pack.sv
module slice_skip_pack
    import slice_recoder_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter int CNT_W = 3
) (
    input  logic [N*DIGIT_W-1:0] digits,
    input  logic [N-1:0]         spec_mask,
    output logic [N-1:0]         nonzero,
    output logic [N*IDX_W-1:0]   index_list,
    output logic [CNT_W-1:0]     count
);
    always_comb begin
        int cnt;
        for (int k = 0; k < N; k++) begin
            nonzero[k] = (digits[k*DIGIT_W +: DIGIT_W] != '0) && !spec_mask[k];
        end
        index_list = '0;
        cnt = 0;
        for (int k = N - 1; k >= 0; k--) begin
            if (nonzero[k]) begin
                index_list[cnt*IDX_W +: IDX_W] = IDX_W'(k);
                cnt = cnt + 1;
            end
        end
        count = CNT_W'(cnt);
    end
endmodule

// File: rtl/slice_recoder.sv
module slice_recoder
    import slice_recoder_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int N     = OP_W / RAW_W,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [OP_W-1:0]      in_operand,
    input  logic [N-1:0]         in_spec_mask,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [N*DIGIT_W-1:0] out_slices,
    output logic [N-1:0]         out_nonzero,
    output logic [N*IDX_W-1:0]   out_index_list,
    output logic [CNT_W-1:0]     out_count
);
    stage_state_e state_q, state_d;
    logic [N*DIGIT_W-1:0] digits_c;
    logic [N-1:0]         nonzero_c;
    logic [N*IDX_W-1:0]   list_c;
    logic [CNT_W-1:0]     count_c;
    logic                 load;

    slice_digit_recode #(.N(N)) u_recode (
        .operand (in_operand),
        .digits  (digits_c)
    );

    slice_skip_pack #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pack (
        .digits     (digits_c),
        .spec_mask  (in_spec_mask),
        .nonzero    (nonzero_c),
        .index_list (list_c),
        .count      (count_c)
    );

    assign load = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;                    // LOAD
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;     // DRAIN
                      else state_d = ST_FULL;                             // STALL / RELOAD
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (load) begin
            out_slices     <= digits_c;
            out_nonzero    <= nonzero_c;
            out_index_list <= list_c;
            out_count      <= count_c;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        in_ready  = (state_q == ST_EMPTY) || out_ready;
    end

    assert_reset_clears_R8: assert property (@(posedge clk) !rst_n |=> !out_valid);

    assert_accept_shows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_slices)
            && $stable(out_nonzero) && $stable(out_count) && $stable(out_index_list));

    assert_count_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_nonzero) == int'(out_count));

    for (genvar g = 0; g < N; g++) begin : g_zero_chk
        assert_zero_skipped_R4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && out_slices[g*DIGIT_W +: DIGIT_W] == '0 |-> !out_nonzero[g]);
    end
endmodule

// File: tb/slice_recoder_tb.sv
module slice_recoder_tb;
    localparam int OP_W = 16;
    localparam int N    = 4;
    localparam int NV   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic [OP_W-1:0] in_operand = '0;
    logic [N-1:0] in_spec_mask = '0;
    logic in_ready, out_valid;
    logic [19:0] out_slices;
    logic [N-1:0] out_nonzero;
    logic [7:0] out_index_list;
    logic [2:0] out_count;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    slice_recoder #(.OP_W(OP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_operand(in_operand), .in_spec_mask(in_spec_mask),
        .out_valid(out_valid), .out_ready(out_ready), .out_slices(out_slices),
        .out_nonzero(out_nonzero), .out_index_list(out_index_list), .out_count(out_count)
    );

    // {operand, mask, slice3, slice2, slice1, slice0}
    localparam logic [39:0] VEC [NV] = '{
        {16'h0000, 4'b0000, 5'h00, 5'h00, 5'h00, 5'h00},
        {16'hFFFF, 4'b0000, 5'h00, 5'h00, 5'h00, 5'h1F},
        {16'h1234, 4'b0000, 5'h01, 5'h02, 5'h03, 5'h04},
        {16'hFF12, 4'b0000, 5'h00, 5'h00, 5'h11, 5'h02},
        {16'h7FFF, 4'b0000, 5'h07, 5'h0F, 5'h0F, 5'h0F},
        {16'h8000, 4'b0000, 5'h18, 5'h00, 5'h00, 5'h00},
        {16'hF0F0, 4'b0000, 5'h00, 5'h10, 5'h0F, 5'h00},
        {16'hFFF0, 4'b0000, 5'h00, 5'h00, 5'h00, 5'h10},
        {16'h1234, 4'b0011, 5'h01, 5'h02, 5'h03, 5'h04},
        {16'hFFFF, 4'b0001, 5'h00, 5'h00, 5'h00, 5'h1F},
        {16'hF0F0, 4'b1000, 5'h00, 5'h10, 5'h0F, 5'h00},
        {16'h0F01, 4'b0000, 5'h00, 5'h0F, 5'h00, 5'h01}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_word(input logic [15:0] op, input logic [3:0] mask,
                              input logic [19:0] exp_sl);
        logic [3:0] enz;
        logic [7:0] elist;
        int ecnt;
        int recon;
        enz = '0; elist = '0; ecnt = 0; recon = 0;
        for (int k = 0; k < N; k++)
            enz[k] = (exp_sl[k*5 +: 5] != 5'd0) && !mask[k];
        for (int k = N - 1; k >= 0; k--)
            if (enz[k]) begin elist[ecnt*2 +: 2] = 2'(k); ecnt++; end
        for (int k = 0; k < N; k++)
            recon += int'($signed(out_slices[k*5 +: 5])) * (1 << (4*k));
        chk("R1/R2 slices", 64'(out_slices), 64'(exp_sl));
        chk("R3 value", 64'(recon), 64'(int'($signed(op))));
        chk("R4 nonzero", 64'(out_nonzero), 64'(enz));
        chk("R5 list", 64'(out_index_list), 64'(elist));
        chk("R5 count", 64'(out_count), 64'(ecnt));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 valid after reset", 64'(out_valid), 64'd0);
        chk("R6 ready when empty", 64'(in_ready), 64'd1);

        // Table walk, one operand at a time
        out_ready = 1'b1;
        for (int i = 0; i < NV; i++) begin
            in_operand   = VEC[i][39:24];
            in_spec_mask = VEC[i][23:20];
            in_valid     = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk("R6 valid after accept", 64'(out_valid), 64'd1);
            check_word(VEC[i][39:24], VEC[i][23:20], VEC[i][19:0]);
            if (i == 1) chk("R9 minus one", 64'(out_slices), 64'h0001F);
        end
        @(negedge clk);
        chk("R6 drained", 64'(out_valid), 64'd0);

        // STALL then RELOAD
        out_ready = 1'b0;
        in_operand = 16'hFFF0; in_spec_mask = 4'b0000; in_valid = 1'b1;
        @(negedge clk);
        in_operand = 16'h1234;
        chk("R7 ready low on stall", 64'(in_ready), 64'd0);
        @(negedge clk);
        chk("R7 valid held", 64'(out_valid), 64'd1);
        check_word(16'hFFF0, 4'b0000, {5'h00, 5'h00, 5'h00, 5'h10});
        out_ready = 1'b1;
        #1;
        chk("R6 ready with out_ready", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check_word(16'h1234, 4'b0000, {5'h01, 5'h02, 5'h03, 5'h04});

        // Reset while holding a word
        out_ready = 1'b0;
        in_valid = 1'b1; in_operand = 16'h0F01;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 held before reset", 64'(out_valid), 64'd1);
        rst_n = 1'b0;
        #1;
        chk("R8 reset clears valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 stays clear", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule